// File: doc/BRIEF.md
# Pipelined Bus Slave with Request Queue

This block is a slave on a pipelined-mode Wishbone bus. A master hands it read and write requests aimed at a small internal register file. Each accepted request goes into a short first-in, first-out queue, so the master can issue requests on consecutive clocks without waiting for earlier ones to finish. A single worker takes requests from the head of the queue and spends a fixed number of clocks on each one. When it is done, it drives a one-clock acknowledge and places the read data on the bus.

Acceptance and completion are separate events. The stall output reports only that the queue has no free slot. The acknowledge reports only that some earlier accepted request has completed, and completions come in the order the requests arrived. If the master drops the cycle signal, the slave discards everything it holds. No write that was still pending takes effect, and no acknowledge follows.

Top module: `pbq_slave`

## Requirements
- R1: A request is accepted on every rising edge where `cyc`, `stb` are high and `stall` is low. While the queue has room, requests presented on consecutive clocks are all accepted with no wait.
- R2: `stall` is high exactly when DEPTH requests are waiting in the queue behind the one held by the worker. With the defaults (DEPTH 4, WORK_CYC 3), a master that keeps presenting requests back to back from an idle slave has six of them accepted. The seventh sees `stall` high.
- R3: A request presented while `stall` is high is not taken. When the master holds it, it is accepted exactly once later. Every accepted request yields exactly one acknowledge.
- R4: Requests complete in the order they were accepted.
- R5: The worker occupies WORK_CYC clocks per request. For an isolated request accepted at edge A on an idle slave, `ack` is high during the clock that follows edge A+WORK_CYC+1.
- R6: `ack` is a single-clock pulse per completed request, and it is never high on two consecutive clocks.
- R7: A read returns the addressed register word on `dat_r` in the clock where `ack` is high. A write returns zero on `dat_r` with its `ack`.
- R8: A write changes only the byte lanes whose `sel` bit is set. Lane i is `dat_w[8i+7:8i]`.
- R9: While `cyc` is low, `ack` is low. On the first rising edge with `cyc` low, every queued and in-progress request is discarded, and a discarded write never changes a register.
- R10: After reset, `stall` and `ack` are low, `dat_r` is zero and every register reads as zero.
- R11: `stb` has no effect while `cyc` is low. Nothing is queued and no `ack` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc | input | 1 | Bus cycle in progress |
| stb | input | 1 | Request strobe |
| we | input | 1 | 1 = write, 0 = read |
| adr | input | AW | Register word address |
| dat_w | input | DW | Write data |
| sel | input | DW/8 | Byte-lane enables for writes |
| dat_r | output | DW | Read data, valid while `ack` is high |
| stall | output | 1 | Queue full, request not taken |
| ack | output | 1 | One earlier request completed |

## Verification
The assertions are evaluated on every cycle. They cover four things: the queue never grows past its depth or pops while empty, an accepted request always leaves something in the queue, `ack` never lasts two clocks, and a low `cyc` always empties the queue and clears the pending acknowledge. Some properties depend on data and order, and only the bench scenarios can show them. These are the exact acknowledge latency, the six-deep burst before `stall` rises, in-order completion with the right read data, byte-lane merging, and a write cancelled by dropping `cyc` never reaching its register.

// File: rtl/pbq_pkg.sv
package pbq_pkg;
   localparam int LANE_W = 8;

   typedef enum logic {
      WK_IDLE = 1'b0,
      WK_BUSY = 1'b1
   } wk_state_e;
endpackage

// File: rtl/pbq_fifo.sv
module pbq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNTW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pbq_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNTW-1:0]  count;

   if (POW2) begin : g_ptr_p2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_ptr_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full  = (count == CNTW'(DEPTH));
   assign empty = (count == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= din;
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

   // R2
   count_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/pbq_regs.sv
module pbq_regs #(
   parameter int DW = 32,
   parameter int AW = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_adr,
   input  logic [DW-1:0]      wr_dat,
   input  logic [DW/8-1:0]    wr_sel,
   input  logic [AW-1:0]      rd_adr,
   output logic [DW-1:0]      rd_dat
);
   import pbq_pkg::*;
   localparam int NREG  = 1 << AW;
   localparam int LANES = DW / LANE_W;

   logic [DW-1:0] word [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && wr_adr == AW'(r)) begin
            for (int l = 0; l < LANES; l++) begin
               if (wr_sel[l]) q[l*LANE_W +: LANE_W] <= wr_dat[l*LANE_W +: LANE_W];
            end
         end
      end
      assign word[r] = q;
   end

   assign rd_dat = word[rd_adr];
endmodule

// File: rtl/pbq_worker.sv
module pbq_worker #(
   parameter int DW       = 32,
   parameter int AW       = 3,
   parameter int WORK_CYC = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cyc,
   input  logic                  q_empty,
   input  logic [AW+DW/8+DW:0]   q_head,
   output logic                  q_pop,
   output logic                  wr_en,
   output logic [AW-1:0]         job_adr,
   output logic [DW-1:0]         job_dat,
   output logic [DW/8-1:0]       job_sel,
   input  logic [DW-1:0]         rd_dat,
   output logic                  ack_q,
   output logic [DW-1:0]         dat_q
);
   import pbq_pkg::*;
   localparam int SW = DW / 8;
   localparam int CW = (WORK_CYC > 1) ? $clog2(WORK_CYC) : 1;

   if (WORK_CYC < 2) begin : g_bad_work
      $error("pbq_worker: WORK_CYC must be at least 2");
   end

   wk_state_e        state;
   logic [CW-1:0]    cnt;
   logic             job_we;
   logic             finishing;

   assign finishing = (state == WK_BUSY) && (cnt == '0);
   assign q_pop     = cyc && !q_empty && ((state == WK_IDLE) || finishing);
   assign wr_en     = cyc && finishing && job_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WK_IDLE;
         cnt     <= '0;
         job_we  <= 1'b0;
         job_adr <= '0;
         job_sel <= '0;
         job_dat <= '0;
         ack_q   <= 1'b0;
         dat_q   <= '0;
      end else if (!cyc) begin
         state <= WK_IDLE;
         cnt   <= '0;
         ack_q <= 1'b0;
      end else begin
         ack_q <= finishing;
         if (finishing) dat_q <= job_we ? '0 : rd_dat;
         if (q_pop) begin
            state   <= WK_BUSY;
            cnt     <= CW'(WORK_CYC - 1);
            job_we  <= q_head[AW+SW+DW];
            job_adr <= q_head[SW+DW +: AW];
            job_sel <= q_head[DW +: SW];
            job_dat <= q_head[DW-1:0];
         end else if (finishing) begin
            state <= WK_IDLE;
         end else if (state == WK_BUSY) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R6
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);

   // R5
   busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop && cyc) |=> (state == WK_BUSY && cnt == CW'(WORK_CYC - 1)));
endmodule

// File: rtl/pbq_slave.sv
module pbq_slave #(
   parameter int DW       = 32,
   parameter int AW       = 3,
   parameter int DEPTH    = 4,
   parameter int WORK_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc,
   input  logic              stb,
   input  logic              we,
   input  logic [AW-1:0]     adr,
   input  logic [DW-1:0]     dat_w,
   input  logic [DW/8-1:0]   sel,
   output logic [DW-1:0]     dat_r,
   output logic              stall,
   output logic              ack
);
   import pbq_pkg::*;
   localparam int SW = DW / LANE_W;
   localparam int RW = 1 + AW + SW + DW;

   if (DW % LANE_W != 0) begin : g_bad_dw
      $error("pbq_slave: DW must be a multiple of the lane width");
   end

   logic          q_full, q_empty, q_push, q_pop;
   logic [RW-1:0] q_din, q_head;
   logic          wr_en, ack_q;
   logic [AW-1:0] job_adr;
   logic [DW-1:0] job_dat, rd_dat;
   logic [SW-1:0] job_sel;

   assign q_push = cyc && stb && !q_full;
   assign q_din  = {we, adr, sel, dat_w};

   pbq_fifo #(.WIDTH(RW), .DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .flush(!cyc),
      .push(q_push), .din(q_din),
      .pop(q_pop), .dout(q_head),
      .full(q_full), .empty(q_empty)
   );

   pbq_worker #(.DW(DW), .AW(AW), .WORK_CYC(WORK_CYC)) u_worker (
      .clk(clk), .rst_n(rst_n), .cyc(cyc),
      .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
      .wr_en(wr_en), .job_adr(job_adr), .job_dat(job_dat), .job_sel(job_sel),
      .rd_dat(rd_dat), .ack_q(ack_q), .dat_q(dat_r)
   );

   pbq_regs #(.DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_adr(job_adr), .wr_dat(job_dat), .wr_sel(job_sel),
      .rd_adr(job_adr), .rd_dat(rd_dat)
   );

   assign stall = q_full;
   assign ack   = ack_q && cyc;

   // R1
   accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc && stb && !stall) |=> !q_empty);

   // R9
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc |=> (q_empty && !ack_q));

   // R11
   idle_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc && stb) |=> !stall);
endmodule

// File: tb/pbq_slave_test.sv
module pbq_slave_test;
   localparam int DW = 32;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [AW-1:0] adr = '0;
   logic [DW-1:0] dat_w = '0;
   logic [3:0]    sel = '0;
   logic [DW-1:0] dat_r;
   logic          stall, ack;

   int errs = 0;
   int checks = 0;
   logic prev_ack = 1'b0;

   typedef struct {
      bit            w;
      int            a;
      logic [DW-1:0] d;
      logic [3:0]    s;
   } item_t;

   item_t         expq[$];
   logic [DW-1:0] model [8];

   pbq_slave #(.DW(DW), .AW(AW), .DEPTH(4), .WORK_CYC(3)) uut (
      .clk(clk), .rst_n(rst_n), .cyc(cyc), .stb(stb), .we(we), .adr(adr),
      .dat_w(dat_w), .sel(sel), .dat_r(dat_r), .stall(stall), .ack(ack)
   );

   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: scoreboard comparison on every acknowledge
   always @(negedge clk) begin
      if (rst_n) begin
         if (ack) begin
            check(!prev_ack, "R6 ack pulse", {31'd0, prev_ack}, '0);
            check(cyc, "R9 ack while cyc low", {31'd0, cyc}, 32'd1);
            if (expq.size() == 0) begin
               check(1'b0, "R3 unexpected ack", dat_r, '0);
            end else begin
               automatic item_t it = expq.pop_front();
               automatic logic [DW-1:0] e;
               if (it.w) begin
                  for (int l = 0; l < 4; l++)
                     if (it.s[l]) model[it.a][l*8 +: 8] = it.d[l*8 +: 8];
                  e = '0;
               end else begin
                  e = model[it.a];
               end
               check(dat_r === e, it.w ? "R7 write data" : "R4/R7/R8 read data", dat_r, e);
            end
         end
         prev_ack = ack;
      end
   end

   // driver: present a request and hold it until taken
   task automatic issue(input bit w, input int a, input logic [DW-1:0] d,
                        input logic [3:0] s, output int waits);
      automatic bit acc;
      stb = 1'b1; we = w; adr = AW'(a); dat_w = d; sel = s;
      waits = 0;
      forever begin
         acc = !stall;
         if (acc) expq.push_back('{w: w, a: a, d: d, s: s});
         @(negedge clk);
         if (acc) break;
         waits++;
      end
   endtask

   task automatic idle(input int n);
      stb = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      automatic int wt;
      automatic int lat;
      automatic int wl [8];
      for (int i = 0; i < 8; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(stall == 1'b0, "R10 stall", {31'd0, stall}, '0);
      check(ack == 1'b0, "R10 ack", {31'd0, ack}, '0);
      check(dat_r == '0, "R10 dat_r", dat_r, '0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc = 1'b1;
      // R10 registers start at zero, R7 read path
      issue(1'b0, 2, '0, 4'hF, wt);
      idle(8);
      // R7 write then read
      issue(1'b1, 1, 32'hA5A5_5A5A, 4'hF, wt);
      issue(1'b0, 1, '0, 4'hF, wt);
      idle(10);
      // R8 partial lanes 0 and 2
      issue(1'b1, 1, 32'h1122_3344, 4'b0101, wt);
      issue(1'b0, 1, '0, 4'hF, wt);
      idle(10);
      // R5 isolated latency
      issue(1'b0, 1, '0, 4'hF, wt);
      stb = 1'b0;
      lat = 0;
      for (int i = 1; i <= 6; i++) begin
         @(negedge clk);
         if (ack && lat == 0) lat = i;
      end
      check(lat == 4, "R5 ack latency", lat, 4);
      idle(4);
      // R1 R2 R3 back-to-back burst of writes
      for (int k = 0; k < 8; k++) begin
         issue(1'b1, k, 32'h1000_0000 + k * 32'h0101, 4'hF, wt);
         wl[k] = wt;
      end
      stb = 1'b0;
      for (int k = 0; k < 6; k++) check(wl[k] == 0, "R1 no wait", wl[k], 0);
      check(wl[6] > 0, "R2 seventh stalled", wl[6], 1);
      idle(40);
      // R4 ordered reads back to back
      for (int k = 7; k >= 0; k--) issue(1'b0, k, '0, 4'hF, wt);
      idle(40);
      check(expq.size() == 0, "R3 one ack per request", expq.size(), 0);
      // R9 abort: writes to reg 5 discarded
      issue(1'b1, 5, 32'hDEAD_BEEF, 4'hF, wt);
      issue(1'b1, 5, 32'hDEAD_BEEF, 4'hF, wt);
      issue(1'b1, 5, 32'hDEAD_BEEF, 4'hF, wt);
      stb = 1'b0;
      cyc = 1'b0;
      expq.delete();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         check(ack == 1'b0, "R9 no ack after cyc drop", {31'd0, ack}, '0);
      end
      // R11 stb while cyc low
      stb = 1'b1; we = 1'b1; adr = 3'd6; dat_w = 32'hFFFF_FFFF; sel = 4'hF;
      repeat (4) @(negedge clk);
      stb = 1'b0;
      cyc = 1'b1;
      repeat (12) @(negedge clk);
      check(stall == 1'b0, "R11 queue empty", {31'd0, stall}, '0);
      issue(1'b0, 5, '0, 4'hF, wt);
      issue(1'b0, 6, '0, 4'hF, wt);
      idle(12);
      check(expq.size() == 0, "R3 R9 R11 all acked", expq.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(5.0 * 50000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule